// File: doc/BRIEF.md
# Interrupt Vector and Priority Sequencer

This block sits beside a small 8-bit processor core and decides which exception the core enters next. Its sources are the reset pin, a software-interrupt instruction, and a set of hardware requests: an external line and three peripheral lines (timer, serial communications, serial peripheral). When it has chosen a source, it performs two vector byte reads, high byte first, at addresses computed from the source. It then raises a one-cycle completion pulse. A set-mask command accompanies that pulse so the core sets its interrupt-mask bit.

A software interrupt is reported in two parts. A marker is raised when the instruction is fetched, and a strobe is raised when the instruction executes. The mask bit has no effect on a software interrupt. At the fetch marker, the block records which hardware lines were already asserted. Lines recorded there that are still asserted and unmasked are served ahead of the software interrupt. Lines that appear only after the fetch wait until the software interrupt has been served. Reset overrides everything else, including a vector sequence that is already under way.

Top module: `intseq_top`

## Requirements
- R1: While `resetN` is low, `vecRd` and `takePulse` stay low. On the first cycle after release, the block reads the reset vector, high byte at 0x1FFE and then low byte at 0x1FFF.
- R2: A reset sequence ends with `takePulse` and `setIBit`.
- R3: A pulse on `swiExec` is served even when `iMask` is 1. Its vector bytes are read from 0x1FFC and then 0x1FFD.
- R4: While `iMask` is 1, no hardware request starts a sequence.
- R5: Unmasked hardware requests are served in a fixed order of bit index of `hwReq`: bit 0 (external line) first, then bit 1 (timer), then bit 2 (serial communications), then bit 3 (serial peripheral). Their vectors are at 0x1FFA, 0x1FF8, 0x1FF6 and 0x1FF4 (high byte). The low byte follows at the next address.
- R6: A hardware line that was asserted when `swiFetch` was pulsed, and that is still asserted and unmasked, is served before the pending software interrupt. This holds even when a higher-priority line has appeared since.
- R7: A hardware line first asserted after the `swiFetch` pulse is served after the pending software interrupt.
- R8: Every completed sequence drives `takePulse` and `setIBit` together for exactly one cycle.
- R9: Pulling `resetN` low in the middle of a vector sequence abandons that sequence. After release, the reset vector is read.
- R10: A sequence occupies three consecutive cycles: the high-byte read, then the low-byte read, then the completion cycle. The first read comes on the cycle after the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| resetN | input | 1 | Active-low reset pin. It is also the reset exception source |
| hwReq | input | 4 | Level hardware requests. Bit 0 is external, 1 timer, 2 serial comms, 3 serial peripheral |
| iMask | input | 1 | Interrupt-mask bit from the core's condition codes |
| swiFetch | input | 1 | Pulse when the software-interrupt instruction is fetched |
| swiExec | input | 1 | Pulse when the software-interrupt instruction requests entry |
| vecRd | output | 1 | A vector byte read is in progress |
| vecAddr | output | 16 | Vector byte address. It is zero when no read is in progress |
| takePulse | output | 1 | One-cycle exception-entry completion |
| setIBit | output | 1 | Command to set the mask bit |

## Verification
The bench drives the following patterns and compares the outputs every cycle against a behavioural model:
- All four hardware lines are held while masked, and the mask is then opened one step at a time. This separates the mask gating from the fixed priority order.
- A software interrupt is issued under the mask. This shows that it bypasses the mask.
- A software interrupt is fetched and executed while another source is being served, with one line raised before the fetch and a higher-priority line raised after it. This is the only pattern that tells the snapshot ordering apart from plain priority.
- Reset is pulled in the middle of a low-byte read. This checks that the abort drops the sequence and restarts at the reset vector.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic latchWin;  // capture the arbitration winner
    logic rdHi;      // high vector byte read cycle
    logic rdLo;      // low vector byte read cycle
    logic retire;    // completion cycle, clears the served source
  } seqStrobe_t;

  // Source numbering; vector high byte = top - 2 * source
  localparam int SRC_RESET   = 0;
  localparam int SRC_SWI     = 1;
  localparam int SRC_HW_BASE = 2;

endpackage

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
  import intseq_pkg::*;
(
  input  logic       clk,
  input  logic       resetN,
  input  logic       ready,
  output seqStrobe_t strobe,
  output logic       takePulse,
  output logic       setIBit
);

  typedef enum logic [2:0] {
    ST_HOLD, ST_IDLE, ST_HI, ST_LO, ST_DONE
  } seqState_t;

  seqState_t state;

  always_ff @(posedge clk) begin
    if (!resetN) begin
      state <= ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD: state <= ST_HI;
        ST_IDLE: state <= ready ? ST_HI : ST_IDLE;
        ST_HI:   state <= ST_LO;
        ST_LO:   state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    strobe.latchWin = (state == ST_IDLE) && ready;
    strobe.rdHi     = (state == ST_HI);
    strobe.rdLo     = (state == ST_LO);
    strobe.retire   = (state == ST_DONE);
    takePulse       = (state == ST_DONE);
    setIBit         = (state == ST_DONE);
  end

  // R10: the high read is followed by the low read and then the completion
  assert_read_then_done_R10: assert property (@(posedge clk) disable iff (!resetN)
    strobe.rdHi |=> strobe.rdLo ##1 takePulse);

  // R8: completion lasts one cycle and always carries the set-mask command
  assert_single_take_R8: assert property (@(posedge clk) disable iff (!resetN)
    takePulse |-> setIBit ##1 !takePulse);

endmodule

// File: rtl/intseq_dp.sv
module intseq_dp
  import intseq_pkg::*;
#(
  parameter int NHW     = 4,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h1FFE
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic [NHW-1:0]    hwReq,
  input  logic              iMask,
  input  logic              swiFetch,
  input  logic              swiExec,
  input  seqStrobe_t        strobe,
  output logic              ready,
  output logic              vecRd,
  output logic [ADDR_W-1:0] vecAddr
);

  localparam int SRC_N = NHW + SRC_HW_BASE;
  localparam int SRC_W = $clog2(SRC_N);

  logic              swiPend;
  logic [NHW-1:0]    snap, snapNext;
  logic [NHW-1:0]    eligHw, earlyHw;
  logic [SRC_W-1:0]  winReg, winNext;
  logic [ADDR_W-1:0] vecBase;
  logic              swiServed;

  assign swiServed = strobe.retire && (winReg == SRC_W'(SRC_SWI));
  assign eligHw    = iMask ? '0 : hwReq;
  assign earlyHw   = eligHw & snap;

  // Per-line fetch-time snapshot: fetch capture wins over retire clearing
  for (genvar g = 0; g < NHW; g++) begin : g_snap
    logic served;
    assign served = strobe.retire && (winReg == SRC_W'(SRC_HW_BASE + g));
    assign snapNext[g] = swiFetch ? hwReq[g]
                       : (served || swiServed) ? 1'b0
                       : snap[g];
  end

  always_ff @(posedge clk) begin
    if (!resetN) begin
      snap    <= '0;
      swiPend <= 1'b0;
    end else begin
      snap <= snapNext;
      if (swiExec)        swiPend <= 1'b1;
      else if (swiServed) swiPend <= 1'b0;
    end
  end

  // Arbitration: lowest line index wins; early lines pre-empt a pending SWI
  always_comb begin
    winNext = SRC_W'(SRC_SWI);
    if (swiPend) begin
      for (int k = NHW - 1; k >= 0; k--)
        if (earlyHw[k]) winNext = SRC_W'(SRC_HW_BASE + k);
    end else begin
      for (int k = NHW - 1; k >= 0; k--)
        if (eligHw[k]) winNext = SRC_W'(SRC_HW_BASE + k);
    end
  end

  assign ready = swiPend || (|eligHw);

  always_ff @(posedge clk) begin
    if (!resetN)             winReg <= SRC_W'(SRC_RESET);
    else if (strobe.latchWin) winReg <= winNext;
  end

  always_comb begin
    vecBase = VEC_TOP - ADDR_W'({winReg, 1'b0});
    if (strobe.rdHi)      vecAddr = vecBase;
    else if (strobe.rdLo) vecAddr = vecBase + ADDR_W'(1);
    else                  vecAddr = '0;
  end

  assign vecRd = strobe.rdHi || strobe.rdLo;

  // R4: under the mask only the software interrupt can be chosen
  assert_mask_blocks_hw_R4: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.latchWin && iMask) |-> (winNext == SRC_W'(SRC_SWI)));

  // R6: the SWI is not chosen while a fetch-time line is still eligible
  assert_early_before_swi_R6: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.latchWin && winNext == SRC_W'(SRC_SWI)) |-> (earlyHw == '0));

  // R7: with a SWI pending, a hardware winner must come from the snapshot
  assert_late_after_swi_R7: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.latchWin && swiPend && winNext != SRC_W'(SRC_SWI)) |-> (|earlyHw));

  // R10: the chosen source holds through the low read and completion
  assert_win_hold_R10: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.rdLo || strobe.retire) |-> $stable(winReg));

endmodule

// File: rtl/intseq_top.sv
module intseq_top
  import intseq_pkg::*;
#(
  parameter int NHW     = 4,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h1FFE
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic [NHW-1:0]    hwReq,
  input  logic              iMask,
  input  logic              swiFetch,
  input  logic              swiExec,
  output logic              vecRd,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              takePulse,
  output logic              setIBit
);

  seqStrobe_t strobe;
  logic       ready;

  intseq_ctrl u_ctrl (
    .clk       (clk),
    .resetN    (resetN),
    .ready     (ready),
    .strobe    (strobe),
    .takePulse (takePulse),
    .setIBit   (setIBit)
  );

  intseq_dp #(
    .NHW     (NHW),
    .ADDR_W  (ADDR_W),
    .VEC_TOP (VEC_TOP)
  ) u_dp (
    .clk      (clk),
    .resetN   (resetN),
    .hwReq    (hwReq),
    .iMask    (iMask),
    .swiFetch (swiFetch),
    .swiExec  (swiExec),
    .strobe   (strobe),
    .ready    (ready),
    .vecRd    (vecRd),
    .vecAddr  (vecAddr)
  );

  // R1: the first read after reset release is the reset vector high byte
  assert_reset_vector_R1: assert property (@(posedge clk)
    $rose(resetN) |=> (vecRd && vecAddr == VEC_TOP));

endmodule

// File: tb/intseq_top_bench.sv
module intseq_top_bench;

  logic        clk = 1'b0;
  logic        resetN = 1'b0;
  logic [3:0]  hwReq = 4'b0;
  logic        iMask = 1'b1;
  logic        swiFetch = 1'b0;
  logic        swiExec = 1'b0;
  logic        vecRd, takePulse, setIBit;
  logic [15:0] vecAddr;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit autoMask = 1;
  bit summaryDone = 0;
  string taken = "";

  always #5 clk = ~clk;

  intseq_top u_intseq_top (
    .clk(clk), .resetN(resetN), .hwReq(hwReq), .iMask(iMask),
    .swiFetch(swiFetch), .swiExec(swiExec), .vecRd(vecRd),
    .vecAddr(vecAddr), .takePulse(takePulse), .setIBit(setIBit)
  );

  // Behavioural reference: -1 reset hold, 0 idle, 1 high read, 2 low read, 3 done
  int mPhase = -1;
  int mSrc = 0;
  bit mSwi = 0;
  bit mSnap [4];
  bit nSwi;
  bit nSnap [4];
  int pick;

  always @(posedge clk) begin
    started = 1;
    if (!resetN) begin
      mPhase = -1; mSrc = 0; mSwi = 0;
      foreach (mSnap[i]) mSnap[i] = 0;
    end else begin
      nSwi = mSwi;
      foreach (mSnap[i]) nSnap[i] = mSnap[i];
      if (mPhase == 3) begin
        if (mSrc == 1) begin
          nSwi = 0;
          foreach (nSnap[i]) nSnap[i] = 0;
        end else if (mSrc >= 2) nSnap[mSrc-2] = 0;
      end
      if (swiFetch) foreach (nSnap[i]) nSnap[i] = hwReq[i];
      if (swiExec) nSwi = 1;
      case (mPhase)
        -1: begin mPhase = 1; mSrc = 0; end
        0: begin
          pick = -1;
          for (int k = 0; k < 4; k++)
            if (pick < 0 && !iMask && hwReq[k] && (!mSwi || mSnap[k])) pick = k + 2;
          if (pick < 0 && mSwi) pick = 1;
          if (pick >= 0) begin mSrc = pick; mPhase = 1; end
        end
        1: mPhase = 2;
        2: mPhase = 3;
        default: mPhase = 0;
      endcase
      mSwi = nSwi;
      foreach (mSnap[i]) mSnap[i] = nSnap[i];
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, sequence log and the core's reaction to completion
  always @(negedge clk) begin
    if (started && !summaryDone) begin
      automatic bit expRd = (mPhase == 1) || (mPhase == 2);
      automatic logic [15:0] expAddr =
        expRd ? 16'(16'h1FFE - 2 * mSrc + (mPhase == 2 ? 1 : 0)) : 16'h0;
      automatic string tag = (mPhase == -1) ? "R1 hold" :
                             (mPhase == 3) ? "R8 completion" : "R10 read cycle";
      check(vecRd == expRd, {tag, " vecRd"}, vecRd, expRd);
      check(vecAddr == expAddr, {tag, " vecAddr"}, vecAddr, expAddr);
      check(takePulse == (mPhase == 3), {tag, " takePulse"}, takePulse, mPhase == 3);
      check(setIBit == (mPhase == 3), {tag, " setIBit"}, setIBit, mPhase == 3);
      if (vecRd && !vecAddr[0])
        taken = {taken, $sformatf("%0d,", (16'h1FFE - vecAddr) >> 1)};
      if (mPhase == 3) begin
        if (autoMask) iMask = 1'b1;
        if (mSrc >= 2) hwReq[mSrc-2] = 1'b0;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expectOrder(string tag, string exp);
    check(taken == exp, tag, taken.len(), exp.len());
    if (taken != exp) $display("FAIL %s order actual=\"%s\" expected=\"%s\"", tag, taken, exp);
    taken = "";
  endtask

  task automatic waitPhase(int p);
    do @(negedge clk); while (mPhase != p);
    #1;
  endtask

  function automatic void summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endfunction

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1, R2: reset hold then reset vector
    cyc(4);
    resetN = 1'b1;
    cyc(6);
    expectOrder("R1 R2 reset vector", "0,");

    // R4: masked requests stay idle
    hwReq = 4'b1111;
    cyc(8);
    expectOrder("R4 masked idle", "");

    // R5: open the mask one step at a time
    for (int i = 0; i < 4; i++) begin
      iMask = 1'b0;
      cyc(6);
    end
    expectOrder("R5 fixed priority", "2,3,4,5,");

    // R3: software interrupt under the mask
    swiFetch = 1'b1; cyc(1); swiFetch = 1'b0;
    swiExec = 1'b1; cyc(1); swiExec = 1'b0;
    cyc(6);
    expectOrder("R3 swi ignores mask", "1,");

    // R6, R7: snapshot ordering while a timer entry is in progress
    autoMask = 0;
    iMask = 1'b0;
    hwReq[1] = 1'b1;
    waitPhase(1);
    hwReq[3] = 1'b1;
    swiFetch = 1'b1;
    cyc(1);
    swiFetch = 1'b0;
    hwReq[0] = 1'b1;
    swiExec = 1'b1;
    cyc(1);
    swiExec = 1'b0;
    cyc(16);
    expectOrder("R6 R7 fetch-time ordering", "3,5,1,2,");

    // R9: reset during the low byte read
    autoMask = 1;
    iMask = 1'b0;
    hwReq[2] = 1'b1;
    waitPhase(2);
    resetN = 1'b0;
    hwReq[2] = 1'b0;
    cyc(2);
    resetN = 1'b1;
    cyc(6);
    expectOrder("R9 reset aborts sequence", "4,0,");

    summary();
    $finish;
  end

endmodule